// File: doc/BRIEF.md
# Slot Event Interrupt Locator

This block gathers hot-plug events for a row of slots and turns them into one interrupt. Each slot owns five sticky event flags: card presence change, isolated power fault, attention button press, retention-lever change and connected power fault. Each slot also owns a seven-bit mask. A slot whose unmasked flags are nonzero lights its own bit in a 32-bit locator word. Locator bit 0 belongs to command completion. Software reads the locator to find the source, then clears flags by writing ones to them.

A control register holds a global interrupt disable, a command-interrupt disable, two stored error-signal disables and a sticky command-detected flag. The interrupt level is high when the global disable is clear and the locator is nonzero. In legacy mode that level drives a wire to the host. In message mode the block instead issues a single one-cycle request each time the level goes from low to high.

Registers are written as whole 32-bit words through a plain write strobe, address and data. Event and command strobes are single-cycle pulses.

Top module: `slot_irq_locator`

## Requirements
- R1: After reset the locator, level, legacy wire and message pulse are all 0. The global disable (control bit 0) is set, and every slot's mask bits are all set, so events raised before any write do not reach the locator.
- R2: A pulse on `evt_strobe[s*5+b]` sets event flag b of slot s: b=0 presence, 1 isolated fault, 2 button, 3 lever, 4 connected fault. One cycle later, locator bit s+1 is 1 exactly when the slot's flags AND NOT its mask bits 4:0 are nonzero. The mask occupies bits 30:24 of the slot word. Mask bits 6:5 are error-signal disables and have no effect on the locator.
- R3: The word for slot s is at byte address 0x24+4*s. A write there clears each flag b whose data bit 16+b is 1. Flags whose data bit is 0 keep their value. The same write loads the mask from data bits 30:24.
- R4: An event strobe in the same cycle as a write that clears the same flag leaves that flag set.
- R5: A pulse on `cmd_strobe` sets command-detected (control bit 16). Locator bit 0 is 1 when command-detected is 1 and command-interrupt disable (control bit 2) is 0. Writing 1 to data bit 16 at address 0x20 clears command-detected. Data bits 3:0 at that address load the four control bits.
- R6: `irq_level` is 1 exactly when global disable is 0 and the locator is nonzero, one cycle after the write or strobe that caused it.
- R7: With `msi_en` high, `msi_pulse` is high for exactly one cycle, the cycle after `irq_level` rises. There is no pulse while the level stays high, and none when it falls. `intx_out` stays 0.
- R8: With `msi_en` low, `intx_out` equals `irq_level` and `msi_pulse` stays 0.
- R9: A write to any address that is neither 0x20 nor a present slot's word changes no state.
- R10: A command strobe in the same cycle as a write that clears command-detected leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_en | input | 1 | 1 selects message requests, 0 selects the legacy level wire |
| evt_strobe | input | NUM_SLOTS*5 | Event pulses, slot s flag b at bit s*5+b |
| cmd_strobe | input | 1 | Command-completion pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the written word |
| reg_wdata | input | 32 | Write data |
| irq_locator | output | 32 | Interrupt source word |
| irq_level | output | 1 | Combined interrupt level |
| intx_out | output | 1 | Legacy interrupt wire |
| msi_pulse | output | 1 | One-cycle message request |

## Verification
Two functions can fall in the same cycle: an event strobe and the clearing write for that same flag, and likewise a command strobe and the clearing of command-detected. The bench drives both in one cycle. It then judges the outcome from the locator in the next cycle, with the slot's mask cleared so that the flag can be seen. A follow-up clearing write, issued alone, shows the flag dropping. This proves the write path was live in the collision cycle and that the strobe won.

// File: rtl/slot_irq_pkg.sv
package slot_irq_pkg;
  localparam int WORD_W      = 32;
  localparam int EVT_BITS    = 5;
  localparam int MASK_BITS   = 7;
  localparam int LATCH_LSB   = 16;
  localparam int MASK_LSB    = 24;
  localparam int CTL_ADDR    = 'h20;
  localparam int SLOT_ADDR0  = 'h24;
  localparam int SLOT_STRIDE = 4;
  localparam int MAX_SLOTS   = WORD_W - 1;

  // control word bit positions
  localparam int CTL_GDIS     = 0;
  localparam int CTL_ERRDIS   = 1;
  localparam int CTL_CMDDIS   = 2;
  localparam int CTL_ARBDIS   = 3;
  localparam int CTL_RW_BITS  = 4;
  localparam int CTL_CMDDET   = 16;

  typedef enum int {
    EV_PRESENCE   = 0,
    EV_ISO_FAULT  = 1,
    EV_BUTTON     = 2,
    EV_LEVER      = 3,
    EV_CONN_FAULT = 4
  } evt_bit_e;

  typedef struct packed {
    logic [MASK_BITS-1:0] mask_d;
    logic [EVT_BITS-1:0]  clr;
  } slot_wr_t;
endpackage

// File: rtl/slot_evt_cell.sv
module slot_evt_cell
  import slot_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [EVT_BITS-1:0] strobe,
  input  logic                wr_hit,
  input  slot_wr_t            wr,
  output logic [EVT_BITS-1:0] latch_q,
  output logic                pending
);
  logic [MASK_BITS-1:0] mask_q;
  logic [EVT_BITS-1:0]  clr_eff;
  logic                 unused_errdis_mask;

  assign clr_eff = wr_hit ? wr.clr : '0;

  // set wins over clear: strobe is OR-ed after the clear term
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      mask_q  <= '1;
    end else begin
      latch_q <= (latch_q & ~clr_eff) | strobe;
      if (wr_hit) mask_q <= wr.mask_d;
    end
  end

  assign pending = |(latch_q & ~mask_q[EVT_BITS-1:0]);
  assign unused_errdis_mask = ^mask_q[MASK_BITS-1:EVT_BITS];
endmodule

// File: rtl/slot_evt_bank.sv
module slot_evt_bank
  import slot_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int ADDR_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SLOTS*EVT_BITS-1:0] strobe,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  slot_wr_t                      wr,
  output logic [NUM_SLOTS-1:0]          pending,
  output logic [NUM_SLOTS*EVT_BITS-1:0] latch_all
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(SLOT_ADDR0 + SLOT_STRIDE * s);
    logic hit;
    assign hit = wr_en && (wr_addr == SLOT_A);
    slot_evt_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (strobe[s*EVT_BITS +: EVT_BITS]),
      .wr_hit  (hit),
      .wr      (wr),
      .latch_q (latch_all[s*EVT_BITS +: EVT_BITS]),
      .pending (pending[s])
    );
  end
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import slot_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_strobe,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [CTL_RW_BITS-1:0] rw_d,
  input  logic                   cmd_det_clr,
  output logic                   glb_dis,
  output logic                   cmd_dis,
  output logic                   cmd_det
);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);
  localparam logic [CTL_RW_BITS-1:0] RW_RESET = CTL_RW_BITS'(1) << CTL_GDIS;

  logic [CTL_RW_BITS-1:0] rw_q;
  logic                   hit;
  logic                   unused_errdis_bits;

  assign hit = wr_en && (wr_addr == CTL_A);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rw_q    <= RW_RESET;
      cmd_det <= 1'b0;
    end else begin
      if (hit) rw_q <= rw_d;
      cmd_det <= (cmd_det & ~(hit & cmd_det_clr)) | cmd_strobe;
    end
  end

  assign glb_dis = rw_q[CTL_GDIS];
  assign cmd_dis = rw_q[CTL_CMDDIS];
  assign unused_errdis_bits = rw_q[CTL_ERRDIS] ^ rw_q[CTL_ARBDIS];
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage
  import slot_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 msi_en,
  input  logic [NUM_SLOTS-1:0] pending,
  input  logic                 cmd_det,
  input  logic                 cmd_dis,
  input  logic                 glb_dis,
  output logic [WORD_W-1:0]    locator,
  output logic                 level,
  output logic                 intx,
  output logic                 msi_pulse
);
  localparam int TOP_BIT = NUM_SLOTS;

  logic last_level_q;

  always_comb begin
    locator            = '0;
    locator[0]         = cmd_det & ~cmd_dis;
    locator[TOP_BIT:1] = pending;
  end

  assign level = ~glb_dis & (|locator);
  assign intx  = level & ~msi_en;

  // last requested level tracks in both modes; pulse only on a rise
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_level_q <= 1'b0;
      msi_pulse    <= 1'b0;
    end else begin
      last_level_q <= level;
      msi_pulse    <= msi_en & level & ~last_level_q;
    end
  end
endmodule

// File: rtl/slot_irq_locator.sv
module slot_irq_locator
  import slot_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int ADDR_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          msi_en,
  input  logic [NUM_SLOTS*EVT_BITS-1:0] evt_strobe,
  input  logic                          cmd_strobe,
  input  logic                          reg_wr,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [WORD_W-1:0]             reg_wdata,
  output logic [WORD_W-1:0]             irq_locator,
  output logic                          irq_level,
  output logic                          intx_out,
  output logic                          msi_pulse
);
  if (NUM_SLOTS < 1 || NUM_SLOTS > MAX_SLOTS) begin : g_bad_cfg
    $error("NUM_SLOTS out of range");
  end

  slot_wr_t                      slot_wr;
  logic [NUM_SLOTS-1:0]          pending;
  logic [NUM_SLOTS*EVT_BITS-1:0] evt_latch_all;
  logic                          glb_dis;
  logic                          cmd_dis;
  logic                          cmd_det;
  logic                          unused_wdata_bits;

  assign slot_wr.clr    = reg_wdata[LATCH_LSB +: EVT_BITS];
  assign slot_wr.mask_d = reg_wdata[MASK_LSB +: MASK_BITS];
  assign unused_wdata_bits = ^{reg_wdata[LATCH_LSB-1:CTL_RW_BITS],
                               reg_wdata[MASK_LSB-1:LATCH_LSB+EVT_BITS],
                               reg_wdata[WORD_W-1:MASK_LSB+MASK_BITS]};

  slot_evt_bank #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (evt_strobe),
    .wr_en     (reg_wr),
    .wr_addr   (reg_addr),
    .wr        (slot_wr),
    .pending   (pending),
    .latch_all (evt_latch_all)
  );

  irq_ctl_reg #(.ADDR_W(ADDR_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_strobe  (cmd_strobe),
    .wr_en       (reg_wr),
    .wr_addr     (reg_addr),
    .rw_d        (reg_wdata[CTL_RW_BITS-1:0]),
    .cmd_det_clr (reg_wdata[CTL_CMDDET]),
    .glb_dis     (glb_dis),
    .cmd_dis     (cmd_dis),
    .cmd_det     (cmd_det)
  );

  irq_out_stage #(.NUM_SLOTS(NUM_SLOTS)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .msi_en    (msi_en),
    .pending   (pending),
    .cmd_det   (cmd_det),
    .cmd_dis   (cmd_dis),
    .glb_dis   (glb_dis),
    .locator   (irq_locator),
    .level     (irq_level),
    .intx      (intx_out),
    .msi_pulse (msi_pulse)
  );
endmodule

// File: rtl/slot_irq_locator_chk.sv
module slot_irq_locator_chk
  import slot_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          msi_en,
  input logic [NUM_SLOTS*EVT_BITS-1:0] evt_strobe,
  input logic                          cmd_strobe,
  input logic [WORD_W-1:0]             irq_locator,
  input logic                          irq_level,
  input logic                          msi_pulse,
  input logic [NUM_SLOTS*EVT_BITS-1:0] evt_latch_all,
  input logic                          glb_dis,
  input logic                          cmd_det
);
  for (genvar i = 0; i < NUM_SLOTS*EVT_BITS; i++) begin : g_flag
    a_r4_strobe_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt_strobe[i] |=> evt_latch_all[i]);
    a_r2_set_only_by_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_strobe[i] |=> !$rose(evt_latch_all[i]));
  end

  a_r10_cmd_strobe_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> cmd_det);

  a_r5_loc0_needs_det: assert property (@(posedge clk) disable iff (!rst_n)
    irq_locator[0] |-> cmd_det);

  a_r6_level_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level |-> (irq_locator != '0) && !glb_dis);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |=> !msi_pulse);

  a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |-> $past(msi_en) && $past(irq_level));
endmodule

bind slot_irq_locator slot_irq_locator_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .msi_en        (msi_en),
  .evt_strobe    (evt_strobe),
  .cmd_strobe    (cmd_strobe),
  .irq_locator   (irq_locator),
  .irq_level     (irq_level),
  .msi_pulse     (msi_pulse),
  .evt_latch_all (evt_latch_all),
  .glb_dis       (glb_dis),
  .cmd_det       (cmd_det)
);

// File: tb/test_slot_irq_locator.sv
module test_slot_irq_locator;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NS = 8;
  localparam int EB = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          msi_en = 1'b0;
  logic [NS*EB-1:0] evt_strobe = '0;
  logic          cmd_strobe = 1'b0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   irq_locator;
  logic          irq_level;
  logic          intx_out;
  logic          msi_pulse;

  slot_irq_locator #(.NUM_SLOTS(NS), .ADDR_W(8)) i_slot_irq_locator (
    .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .evt_strobe(evt_strobe),
    .cmd_strobe(cmd_strobe), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq_locator(irq_locator), .irq_level(irq_level),
    .intx_out(intx_out), .msi_pulse(msi_pulse)
  );

  always #2.5ns clk = ~clk;

  typedef struct {
    int          due;
    int          field;   // 0 locator, 1 level, 2 legacy wire, 3 message pulse
    logic [31:0] val;
    string       req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 0;

  function automatic logic [31:0] actual(input int f);
    case (f)
      0:       return irq_locator;
      1:       return {31'b0, irq_level};
      2:       return {31'b0, intx_out};
      default: return {31'b0, msi_pulse};
    endcase
  endfunction

  // monitor: pops every item due in this cycle and compares
  initial forever begin
    @(posedge clk);
    cyc++;
    #1ns;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        n_chk++;
        if (actual(q[i].field) !== q[i].val) begin
          n_fail++;
          $display("FAIL %s field %0d at cycle %0d: got %h expected %h",
                   q[i].req, q[i].field, cyc, actual(q[i].field), q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic push(input int dly, input int f, input logic [31:0] v, input string r);
    exp_t e;
    e.due = cyc + dly; e.field = f; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  task automatic exp_out(input string r, input logic [31:0] loc, input logic lvl, input logic ix);
    push(1, 0, loc, r);
    push(1, 1, {31'b0, lvl}, r);
    push(1, 2, {31'b0, ix}, r);
  endtask

  task automatic exp_msi(input int dly, input string r, input logic m);
    push(dly, 3, {31'b0, m}, r);
  endtask

  // driver: one cycle of stimulus starting at a falling edge
  task automatic step(input int eidx, input bit cmd, input bit w,
                      input logic [7:0] a, input logic [31:0] d);
    if (eidx >= 0) evt_strobe[eidx] = 1'b1;
    cmd_strobe = cmd;
    reg_wr     = w;
    reg_addr   = a;
    reg_wdata  = d;
    @(negedge clk);
    evt_strobe = '0;
    cmd_strobe = 1'b0;
    reg_wr     = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(-1, 1'b0, 1'b1, a, d);
  endtask

  function automatic logic [7:0] sa(input int s);
    return 8'(8'h24 + 4 * s);
  endfunction

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    exp_out("R1", 32'h0, 1'b0, 1'b0); exp_msi(1, "R1", 1'b0);
    @(negedge clk);
    // R1 masks set at reset: event stays hidden
    exp_out("R1", 32'h0, 1'b0, 1'b0); step(2*EB + 0, 0, 0, 8'h0, 0);
    // R6 locator visible but global disable keeps level low
    exp_out("R6", 32'h8, 1'b0, 1'b0); wr(sa(2), 32'h0);
    // R8 legacy wire follows level, no message
    exp_out("R8", 32'h8, 1'b1, 1'b1); exp_msi(2, "R8", 1'b0); wr(8'h20, 32'h0);
    // R2 error-signal mask bits have no effect; presence mask hides
    exp_out("R2", 32'h8, 1'b1, 1'b1); wr(sa(2), 32'h6000_0000);
    exp_out("R2", 32'h0, 1'b0, 1'b0); wr(sa(2), 32'h0100_0000);
    exp_out("R2", 32'h8, 1'b1, 1'b1); wr(sa(2), 32'h0);
    // R3 clear of another flag leaves it; clear of its own drops it
    exp_out("R3", 32'h8, 1'b1, 1'b1); wr(sa(2), 32'h0002_0000);
    exp_out("R3", 32'h0, 1'b0, 1'b0); wr(sa(2), 32'h0001_0000);
    // R4 collision of set and clear on slot 5 lever flag
    exp_out("R4", 32'h0, 1'b0, 1'b0); wr(sa(5), 32'h0);
    exp_out("R4", 32'h40, 1'b1, 1'b1); step(5*EB + 3, 0, 1, sa(5), 32'h0008_0000);
    exp_out("R4", 32'h0, 1'b0, 1'b0); wr(sa(5), 32'h0008_0000);
    // R5 command detected and its disable
    exp_out("R5", 32'h1, 1'b1, 1'b1); step(-1, 1, 0, 8'h0, 0);
    exp_out("R5", 32'h0, 1'b0, 1'b0); wr(8'h20, 32'h4);
    exp_out("R5", 32'h1, 1'b1, 1'b1); wr(8'h20, 32'h0);
    exp_out("R5", 32'h0, 1'b0, 1'b0); wr(8'h20, 32'h0001_0000);
    // R10 command strobe wins over its clear
    exp_out("R10", 32'h1, 1'b1, 1'b1); step(-1, 1, 1, 8'h20, 32'h0001_0000);
    exp_out("R10", 32'h0, 1'b0, 1'b0); wr(8'h20, 32'h0001_0000);
    // R7 message mode: one pulse on rise only
    msi_en = 1'b1;
    @(negedge clk);
    exp_out("R7", 32'h40, 1'b1, 1'b0); exp_msi(2, "R7", 1'b1); exp_msi(3, "R7", 1'b0);
    step(5*EB + 0, 0, 0, 8'h0, 0);
    exp_out("R7", 32'h48, 1'b1, 1'b0); step(2*EB + 2, 0, 0, 8'h0, 0);
    exp_out("R7", 32'h08, 1'b1, 1'b0); exp_msi(2, "R7", 1'b0); wr(sa(5), 32'h0001_0000);
    exp_out("R7", 32'h0, 1'b0, 1'b0); exp_msi(2, "R7", 1'b0); wr(sa(2), 32'h0004_0000);
    // R8 back to legacy: rise gives wire, no message
    msi_en = 1'b0;
    @(negedge clk);
    exp_out("R8", 32'h8, 1'b1, 1'b1); exp_msi(2, "R8", 1'b0); step(2*EB + 0, 0, 0, 8'h0, 0);
    exp_out("R8", 32'h0, 1'b0, 1'b0); exp_msi(2, "R8", 1'b0); wr(sa(2), 32'h0001_0000);
    // R9 stray addresses: slot 1 mask must stay set
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h25, 32'h0);
    wr(sa(NS), 32'h0);
    exp_out("R9", 32'h0, 1'b0, 1'b0); step(1*EB + 0, 0, 0, 8'h0, 0);
    // R2 highest slot maps to bit NS
    exp_out("R2", 32'h0, 1'b0, 1'b0); wr(sa(NS-1), 32'h0);
    exp_out("R2", 32'h100, 1'b1, 1'b1); step((NS-1)*EB + 4, 0, 0, 8'h0, 0);
    repeat (5) @(negedge clk);
    if (q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    finished = 1;
    summary();
    $finish;
  end
endmodule